// File: doc/BRIEF.md
# Saturating Multiply-Accumulate and Shift Engine

This block is the arithmetic datapath of a 16-bit signal-processing controller. On each accepted command it can do one of four things. It can multiply two 16-bit operands and add the product to one of two 40-bit accumulators. It can subtract the product from an accumulator. It can load the product into an accumulator, or clear an accumulator. Signed and unsigned operands go through the same 17x17 multiplier: each 16-bit operand is widened by one bit before it enters the array. A fractional mode doubles the product, so that Q15 times Q15 gives a Q31 result.

Every accumulator write passes through one 41-bit adder with clamping. In normal mode the clamp limits are the 32-bit signed range. In extended mode they are the full 40-bit signed range, so the eight guard bits above bit 31 can absorb growth. Each accumulator has a sticky clamp flag and a guard-overflow flag.

A single-cycle bidirectional barrel shifter takes a signed amount. It shifts either the selected accumulator or a sign-extended 16-bit register value, and places the result in a separate output register. The shift leaves both accumulators untouched. Operand fetch and instruction decode sit outside this block. They present one command per cycle, and all results are registered and visible one clock edge after the command is sampled.

Top module: `dsp_mac_engine`

## Requirements
- R1: After reset (rst_n low), both accumulators, both clamp flags, both guard flags and shift_out are zero.
- R2: Command 1 (accumulate) adds the product op_a*op_b to the accumulator picked by acc_sel (0 or 1). The other accumulator keeps its value. With op_signed=1 both operands are two's complement.
- R3: With op_signed=0 both operands are unsigned (zero-extended to 17 bits), so 0xFFFF*0xFFFF gives 0x00FFFE0001.
- R4: Command 2 (deduct) subtracts the product from the selected accumulator.
- R5: Command 3 (load) writes the product, after clamping, into the selected accumulator and discards the old value.
- R6: With frac_mode=1 the product is doubled. Signed 0x8000*0x8000 in that mode gives 0x007FFFFFFF instead of 2^31.
- R7: With super_sat=0, an arithmetic result above 2^31-1 becomes 0x007FFFFFFF and one below -2^31 becomes 0xFF80000000. The clamp sets the sticky flag (sat0/sat1) of that accumulator.
- R8: With super_sat=1 the clamp limits are 0x7FFFFFFFFF and 0x8000000000. Reaching them sets the sticky flag in the same way.
- R9: guard0/guard1 is 1 exactly when bits 39 down to 31 of that accumulator are not all equal.
- R10: Command 5 places the selected accumulator, shifted by shift_amt, into shift_out. shift_amt is 5-bit two's complement: a positive amount (up to 15) shifts right arithmetically, and a negative amount (down to -16) shifts left with zero fill. Neither accumulator changes.
- R11: Command 6 applies the same shift to op_a sign-extended to 40 bits and writes the result to shift_out.
- R12: Command 4 (clear) zeroes the selected accumulator and its sticky flag.
- R13: While cmd_valid is 0, or with command 0 (idle), no accumulator, flag or shift_out changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 3 | Command code: 0 idle, 1 accumulate, 2 deduct, 3 load, 4 clear, 5 shift accumulator, 6 shift register value |
| acc_sel | input | 1 | Target or source accumulator |
| op_signed | input | 1 | Operands are two's complement |
| frac_mode | input | 1 | Double the product |
| super_sat | input | 1 | Clamp at 40-bit rather than 32-bit limits |
| op_a | input | 16 | First multiplier operand; shifter source for command 6 |
| op_b | input | 16 | Second multiplier operand |
| shift_amt | input | 5 | Signed shift amount |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| sat0 | output | 1 | Sticky clamp flag of accumulator 0 |
| sat1 | output | 1 | Sticky clamp flag of accumulator 1 |
| guard0 | output | 1 | Guard-bit overflow of accumulator 0 |
| guard1 | output | 1 | Guard-bit overflow of accumulator 1 |
| shift_out | output | 40 | Registered shifter result |

## Verification
The properties assume that reset is applied before the first command, and that cmd carries only the codes 0 to 6. They also assume that every input stays steady around the sampling edge, so that the registered result relates to the inputs one cycle earlier. The stimulus uses only the listed codes and changes every input on the falling clock edge. It uses the clamp modes exactly as each scenario describes. This means a guard overflow can only appear after an extended-mode write, which is the behaviour the guard property relies on.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        OP_IDLE  = 3'd0,
        OP_ACC   = 3'd1,
        OP_DED   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4,
        OP_SHACC = 3'd5,
        OP_SHREG = 3'd6
    } mac_op_e;

endpackage

// File: rtl/dsp_mac_mult.sv
// Widened multiplier: both operands gain one bit (sign or zero), so one
// signed array serves both operand kinds. Result sign-extended to ACC_W.
module dsp_mac_mult #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_signed,
    input  logic              frac,
    output logic [ACC_W-1:0]  prod
);
    localparam int EXT_W  = DATA_W + 1;
    localparam int PROD_W = 2 * EXT_W;
    localparam int PAD_W  = ACC_W - PROD_W;
    localparam int MAXF_W = 2 * DATA_W - 1;

    logic signed [EXT_W-1:0]  a_ext;
    logic signed [EXT_W-1:0]  b_ext;
    logic signed [PROD_W-1:0] raw;
    logic        [ACC_W-1:0]  wide;
    logic                     both_min;

    always_comb begin
        a_ext    = {is_signed & a[DATA_W-1], a};
        b_ext    = {is_signed & b[DATA_W-1], b};
        raw      = a_ext * b_ext;
        wide     = {{PAD_W{raw[PROD_W-1]}}, raw};
        both_min = is_signed
                 && (a == {1'b1, {(DATA_W-1){1'b0}}})
                 && (b == {1'b1, {(DATA_W-1){1'b0}}});
        if (!frac) begin
            prod = wide;
        end else if (both_min) begin
            prod = {{(ACC_W-MAXF_W){1'b0}}, {MAXF_W{1'b1}}};
        end else begin
            prod = wide << 1;
        end
    end
endmodule

// File: rtl/dsp_mac_addsat.sv
// One shared add/subtract path with clamping at 32-bit or 40-bit limits.
module dsp_mac_addsat #(
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] prod,
    input  logic             subtract,
    input  logic             load,
    input  logic             super_sat,
    output logic [ACC_W-1:0] result,
    output logic             clamped
);
    localparam int SAT_W = ACC_W - GUARD_W;
    localparam int SUM_W = ACC_W + 1;

    logic signed [SUM_W-1:0] base_x;
    logic signed [SUM_W-1:0] prod_x;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] lim_hi;
    logic signed [SUM_W-1:0] lim_lo;

    always_comb begin
        base_x = load ? '0 : {acc[ACC_W-1], acc};
        prod_x = {prod[ACC_W-1], prod};
        sum    = subtract ? (base_x - prod_x) : (base_x + prod_x);
        if (super_sat) begin
            lim_hi = {2'b00, {(ACC_W-1){1'b1}}};
            lim_lo = {2'b11, {(ACC_W-1){1'b0}}};
        end else begin
            lim_hi = {{(SUM_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
            lim_lo = {{(SUM_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};
        end
        if (sum > lim_hi) begin
            result  = lim_hi[ACC_W-1:0];
            clamped = 1'b1;
        end else if (sum < lim_lo) begin
            result  = lim_lo[ACC_W-1:0];
            clamped = 1'b1;
        end else begin
            result  = sum[ACC_W-1:0];
            clamped = 1'b0;
        end
    end
endmodule

// File: rtl/dsp_mac_shifter.sv
// Single-cycle barrel shifter: positive amount = arithmetic right,
// negative amount = left with zero fill.
module dsp_mac_shifter #(
    parameter int ACC_W   = 40,
    parameter int SHAMT_W = 5
) (
    input  logic [ACC_W-1:0]   src,
    input  logic [SHAMT_W-1:0] amt,
    output logic [ACC_W-1:0]   res
);
    logic [SHAMT_W:0] left_mag;

    always_comb begin
        left_mag = {1'b0, ~amt} + 1'b1;
        if (amt[SHAMT_W-1]) begin
            res = src << left_mag;
        end else begin
            res = $unsigned($signed(src) >>> amt);
        end
    end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
    import dsp_mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8,
    parameter int SHAMT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [CMD_W-1:0]   cmd,
    input  logic               acc_sel,
    input  logic               op_signed,
    input  logic               frac_mode,
    input  logic               super_sat,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [SHAMT_W-1:0] shift_amt,
    output logic [ACC_W-1:0]   acc0,
    output logic [ACC_W-1:0]   acc1,
    output logic               sat0,
    output logic               sat1,
    output logic               guard0,
    output logic               guard1,
    output logic [ACC_W-1:0]   shift_out
);
    localparam int NUM_ACC = 2;
    localparam int SAT_W   = ACC_W - GUARD_W;
    localparam int TOP_W   = GUARD_W + 1;

    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
        logic [NUM_ACC-1:0]            sticky;
        logic [NUM_ACC-1:0]            guard;
        logic [ACC_W-1:0]              shres;
    } eng_state_t;

    eng_state_t st_d, st_q;

    mac_op_e          op;
    logic [ACC_W-1:0] sel_acc;
    logic [ACC_W-1:0] product;
    logic [ACC_W-1:0] arith_res;
    logic             arith_clamp;
    logic [ACC_W-1:0] sh_src;
    logic [ACC_W-1:0] sh_res;

    assign op      = mac_op_e'(cmd);
    assign sel_acc = st_q.acc[acc_sel];
    assign sh_src  = (op == OP_SHREG)
                   ? {{(ACC_W-DATA_W){op_a[DATA_W-1]}}, op_a}
                   : sel_acc;

    dsp_mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
        .a         (op_a),
        .b         (op_b),
        .is_signed (op_signed),
        .frac      (frac_mode),
        .prod      (product)
    );

    dsp_mac_addsat #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_addsat (
        .acc       (sel_acc),
        .prod      (product),
        .subtract  (op == OP_DED),
        .load      (op == OP_LOAD),
        .super_sat (super_sat),
        .result    (arith_res),
        .clamped   (arith_clamp)
    );

    dsp_mac_shifter #(.ACC_W(ACC_W), .SHAMT_W(SHAMT_W)) u_shift (
        .src (sh_src),
        .amt (shift_amt),
        .res (sh_res)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            unique case (op)
                OP_ACC, OP_DED, OP_LOAD: begin
                    st_d.acc[acc_sel] = arith_res;
                    if (arith_clamp) begin
                        st_d.sticky[acc_sel] = 1'b1;
                    end
                end
                OP_CLEAR: begin
                    st_d.acc[acc_sel]    = '0;
                    st_d.sticky[acc_sel] = 1'b0;
                end
                OP_SHACC, OP_SHREG: begin
                    st_d.shres = sh_res;
                end
                default: begin
                end
            endcase
        end
        for (int i = 0; i < NUM_ACC; i++) begin
            st_d.guard[i] = !((&st_d.acc[i][ACC_W-1 -: TOP_W])
                           || (~|st_d.acc[i][ACC_W-1 -: TOP_W]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc0      = st_q.acc[0];
    assign acc1      = st_q.acc[1];
    assign sat0      = st_q.sticky[0];
    assign sat1      = st_q.sticky[1];
    assign guard0    = st_q.guard[0];
    assign guard1    = st_q.guard[1];
    assign shift_out = st_q.shres;

    if (SAT_W < 2 * DATA_W) begin : g_width_check
        initial $error("clamp width narrower than full product");
    end
endmodule

// File: rtl/dsp_mac_engine_chk.sv
module dsp_mac_engine_chk
    import dsp_mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8,
    parameter int SHAMT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [CMD_W-1:0]   cmd,
    input logic               acc_sel,
    input logic               op_signed,
    input logic               frac_mode,
    input logic               super_sat,
    input logic [DATA_W-1:0]  op_a,
    input logic [DATA_W-1:0]  op_b,
    input logic [SHAMT_W-1:0] shift_amt,
    input logic [ACC_W-1:0]   acc0,
    input logic [ACC_W-1:0]   acc1,
    input logic               sat0,
    input logic               sat1,
    input logic               guard0,
    input logic               guard1,
    input logic [ACC_W-1:0]   shift_out
);
    localparam int TOP_W = GUARD_W + 1;

    logic arith;
    assign arith = cmd_valid && (cmd == OP_ACC || cmd == OP_DED || cmd == OP_LOAD);

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(acc0) && $stable(acc1) && $stable(shift_out)
                        && $stable(sat0) && $stable(sat1)));

    assert_other_acc0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && acc_sel) |=> $stable(acc0));

    assert_other_acc1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !acc_sel) |=> $stable(acc1));

    assert_norm_range0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && !super_sat && !acc_sel)
        |=> ((&acc0[ACC_W-1 -: TOP_W]) || (~|acc0[ACC_W-1 -: TOP_W])));

    assert_norm_range1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && !super_sat && acc_sel)
        |=> ((&acc1[ACC_W-1 -: TOP_W]) || (~|acc1[ACC_W-1 -: TOP_W])));

    assert_guard_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(guard0) || $rose(guard1)) |-> $past(super_sat && arith));

    assert_sticky_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat0) |-> $past(cmd_valid && cmd == OP_CLEAR && !acc_sel));

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == OP_CLEAR && acc_sel) |=> (acc1 == '0 && !sat1 && !guard1));

    assert_shift_keeps_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd == OP_SHACC || cmd == OP_SHREG))
        |=> ($stable(acc0) && $stable(acc1)));
endmodule

bind dsp_mac_engine dsp_mac_engine_chk #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .GUARD_W(GUARD_W), .SHAMT_W(SHAMT_W)
) u_chk (.*);

// File: tb/dsp_mac_engine_tb.sv
`timescale 1ns/1ps
module dsp_mac_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic        acc_sel = 1'b0;
    logic        op_signed = 1'b0;
    logic        frac_mode = 1'b0;
    logic        super_sat = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [4:0]  shift_amt = '0;
    logic [39:0] acc0, acc1, shift_out;
    logic        sat0, sat1, guard0, guard1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dsp_mac_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .acc_sel(acc_sel), .op_signed(op_signed), .frac_mode(frac_mode),
        .super_sat(super_sat), .op_a(op_a), .op_b(op_b), .shift_amt(shift_amt),
        .acc0(acc0), .acc1(acc1), .sat0(sat0), .sat1(sat1),
        .guard0(guard0), .guard1(guard1), .shift_out(shift_out)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on falling edge; result registered at next rising edge, sampled at following fall
    task automatic issue(input logic [2:0] c, input logic sel, input logic sg,
                         input logic fr, input logic sp, input logic [15:0] a,
                         input logic [15:0] b, input logic [4:0] amt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; acc_sel = sel; op_signed = sg;
        frac_mode = fr; super_sat = sp; op_a = a; op_b = b; shift_amt = amt;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 acc0", acc0, 40'h0);
        chk("R1 acc1", acc1, 40'h0);
        chk("R1 flags", {36'h0, sat0, sat1, guard0, guard1}, 40'h0);
        chk("R1 shift_out", shift_out, 40'h0);
    endtask

    task automatic t_signed_accumulate();
        issue(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd3, 16'hFFFB, 5'd0);
        chk("R2 acc0 3*-5", acc0, 40'hFF_FFFF_FFF1);
        issue(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd100, 16'd200, 5'd0);
        chk("R2 acc0 sum", acc0, 40'h00_0000_4E11);
        chk("R2 acc1 untouched", acc1, 40'h0);
    endtask

    task automatic t_unsigned_load();
        issue(3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 5'd0);
        chk("R3 R5 acc1 unsigned load", acc1, 40'h00_FFFE_0001);
        chk("R9 guard1 set", {39'h0, guard1}, 40'h1);
        chk("R8 sat1 clear", {39'h0, sat1}, 40'h0);
        chk("R2 acc0 untouched", acc0, 40'h00_0000_4E11);
    endtask

    task automatic t_deduct();
        issue(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'd10, 16'd10, 5'd0);
        chk("R4 acc0 deduct", acc0, 40'h00_0000_4DAD);
    endtask

    task automatic t_fractional();
        issue(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 5'd0);
        chk("R12 acc0 cleared", acc0, 40'h0);
        issue(3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000, 5'd0);
        chk("R6 min*min clamp", acc0, 40'h00_7FFF_FFFF);
        chk("R6 no sticky", {39'h0, sat0}, 40'h0);
        issue(3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 16'h4000, 16'h4000, 5'd0);
        chk("R6 half*half", acc0, 40'h00_2000_0000);
    endtask

    task automatic t_normal_clamp();
        issue(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h7FFF, 16'h7FFF, 5'd0);
        chk("R2 integer accumulate", acc0, 40'h00_5FFF_0001);
        issue(3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 5'd0);
        chk("R7 positive clamp", acc0, 40'h00_7FFF_FFFF);
        chk("R7 sat0 set", {39'h0, sat0}, 40'h1);
        chk("R9 guard0 clear", {39'h0, guard0}, 40'h0);
        issue(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 5'd0);
        chk("R12 sat0 cleared", {39'h0, sat0}, 40'h0);
        issue(3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 5'd0);
        chk("R4 frac deduct", acc0, 40'hFF_8001_FFFE);
        chk("R7 sat0 still clear", {39'h0, sat0}, 40'h0);
        issue(3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 5'd0);
        chk("R7 negative clamp", acc0, 40'hFF_8000_0000);
        chk("R7 sat0 set again", {39'h0, sat0}, 40'h1);
    endtask

    task automatic t_super_clamp();
        longint exp_v = 64'h00_FFFE_0001;
        for (int k = 0; k < 130; k++) begin
            issue(3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 5'd0);
            exp_v = exp_v + 64'hFFFE_0001;
            if (exp_v > 64'h7F_FFFF_FFFF) exp_v = 64'h7F_FFFF_FFFF;
            if (k == 0) chk("R8 no early clamp", {39'h0, sat1}, 40'h0);
        end
        chk("R8 acc1 40-bit clamp", acc1, exp_v[39:0]);
        chk("R8 sat1 set", {39'h0, sat1}, 40'h1);
        chk("R9 guard1 set", {39'h0, guard1}, 40'h1);
    endtask

    task automatic t_shift_acc();
        issue(3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 5'b00100);
        chk("R10 acc1 right 4", shift_out, 40'h07_FFFF_FFFF);
        chk("R10 acc1 unchanged", acc1, 40'h7F_FFFF_FFFF);
        issue(3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 5'b10000);
        chk("R10 acc1 left 16", shift_out, 40'hFF_FFFF_0000);
        issue(3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 5'b01111);
        chk("R10 acc0 arith right 15", shift_out, 40'hFF_FFFF_0000);
        chk("R10 acc0 unchanged", acc0, 40'hFF_8000_0000);
        issue(3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 5'b00000);
        chk("R10 zero shift", shift_out, 40'h7F_FFFF_FFFF);
    endtask

    task automatic t_shift_reg();
        issue(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001, 16'h0, 5'b10000);
        chk("R11 reg left 16", shift_out, 40'hFF_8001_0000);
        issue(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001, 16'h0, 5'b00001);
        chk("R11 reg right 1", shift_out, 40'hFF_FFFF_C000);
        issue(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0, 5'b11100);
        chk("R11 reg left 4", shift_out, 40'h00_0001_2340);
        chk("R11 acc0 unchanged", acc0, 40'hFF_8000_0000);
    endtask

    task automatic t_idle();
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd1; acc_sel = 1'b0; op_signed = 1'b1;
        op_a = 16'h1111; op_b = 16'h2222;
        repeat (3) @(negedge clk);
        chk("R13 invalid acc0 held", acc0, 40'hFF_8000_0000);
        cmd = 3'd6;
        @(negedge clk);
        chk("R13 invalid shift held", shift_out, 40'h00_0001_2340);
        issue(3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h1111, 16'h2222, 5'd3);
        chk("R13 idle acc1 held", acc1, 40'h7F_FFFF_FFFF);
        chk("R13 idle flags held", {36'h0, sat0, sat1, guard0, guard1}, 40'hD);
    endtask

    task automatic t_clear_acc1();
        issue(3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 5'd0);
        chk("R12 acc1 cleared", acc1, 40'h0);
        chk("R12 sat1 guard1 cleared", {38'h0, sat1, guard1}, 40'h0);
        chk("R12 acc0 kept", acc0, 40'hFF_8000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed_accumulate();
        t_unsigned_load();
        t_deduct();
        t_fractional();
        t_normal_clamp();
        t_super_clamp();
        t_shift_acc();
        t_shift_reg();
        t_idle();
        t_clear_acc1();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule